// File: doc/BRIEF.md
# Per-Flow Credit Gate with Congestion Marking

This block decides which of several flows may place a packet on one shared output link in each cycle. Every flow owns a credit counter. A flow that has a packet waiting and at least one credit is eligible. A round-robin arbiter picks one eligible flow per cycle and spends one of its credits. A flow with no credit simply drops out of the candidate set, so it never holds up the other flows. The receiver gives credits back through a return port, one credit per event, and the counter never goes above a configured ceiling.

Independently of credit state, the block compares a shared-buffer occupancy input against half of the buffer depth at the moment of each grant. Above that point, the granted packet leaves with a congestion mark. The granted flow index and the mark are held in an output register with a valid/ready handshake. The requesting side is told which flow was taken through a one-hot pop vector in the grant cycle.

Top module: `flow_credit_gate`

## Requirements
- R1: After reset, the output is not valid, no pop is issued, and every flow holds `INIT_CREDIT` credits, so a flow with no returns is granted exactly `INIT_CREDIT` times.
- R2: A flow whose credit count is zero is never granted, even while it requests.
- R3: When the output can accept a packet and at least one requesting flow has credit, a grant is issued in that cycle, whatever state the other flows are in.
- R4: A return event (`ret_valid_i` with `ret_flow_i` = flow index) adds one credit to that flow, and the count saturates at `MAX_CREDIT`.
- R5: A return and a grant for the same flow in the same cycle leave that flow's count unchanged.
- R6: Eligible flows are served round-robin. The search starts at the flow after the last one granted, and after reset flow 0 has first priority.
- R7: A packet granted while `occ_i` is greater than `BUF_DEPTH/2` appears at the output with `out_mark_o` = 1.
- R8: A packet granted while `occ_i` is at most `BUF_DEPTH/2` appears with `out_mark_o` = 0.
- R9: `flow_pop_o` is one-hot at bit `f` in the cycle flow `f` is granted and zero otherwise. A grant is only issued when the output register is empty or is being consumed. While `out_valid_o` = 1 and `out_ready_i` = 0, the flow index and mark are held unchanged. A granted packet appears at the output in the cycle after its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_req_i | input | NUM_FLOWS | Per-flow packet-waiting flags |
| flow_pop_o | output | NUM_FLOWS | One-hot: the flow granted in this cycle |
| ret_valid_i | input | 1 | A credit return event is present |
| ret_flow_i | input | FLOW_W | Flow receiving the returned credit |
| occ_i | input | OCC_W | Current shared-buffer occupancy, 0 to BUF_DEPTH |
| out_valid_o | output | 1 | Output register holds a packet |
| out_ready_i | input | 1 | The link accepts the output packet |
| out_flow_o | output | FLOW_W | Flow index of the output packet |
| out_mark_o | output | 1 | Congestion mark of the output packet |

## Verification
On every cycle the assertions check that a grant never lands on a flow without credit and is always one-hot, that a stalled output is held stable, that every counter stays within its ceiling, that a return plus grant on one flow leaves its count fixed, and that the mark follows the occupancy threshold seen at grant time. The bench scenarios cover the behaviour that only shows over a sequence of cycles. These are the exact round-robin order, the total number of grants that the initial credits and saturated returns allow, a starved flow leaving the others running, and the one-cycle path from grant to output under back-pressure.

// File: rtl/fcg_pkg.sv
`timescale 1ns/1ps
package fcg_pkg;

    // Per-cycle action applied to one credit counter
    typedef enum logic [1:0] {
        CR_HOLD = 2'd0,
        CR_ADD  = 2'd1,
        CR_TAKE = 2'd2
    } cr_op_e;

    // A grant and a return in the same cycle cancel; a return at the ceiling is dropped
    function automatic cr_op_e cr_op(input logic take, input logic add, input logic at_max);
        cr_op_e op;
        op = CR_HOLD;
        if (take && !add)
            op = CR_TAKE;
        else if (add && !take && !at_max)
            op = CR_ADD;
        return op;
    endfunction

endpackage

// File: rtl/fcg_credit_bank.sv
`timescale 1ns/1ps
module fcg_credit_bank
    import fcg_pkg::*;
#(
    parameter  int NUM_FLOWS   = 4,
    parameter  int MAX_CREDIT  = 8,
    parameter  int INIT_CREDIT = 4,
    localparam int CREDIT_W    = $clog2(MAX_CREDIT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLOWS-1:0] take_i,
    input  logic [NUM_FLOWS-1:0] add_i,
    output logic [NUM_FLOWS-1:0] live_o
);

    typedef struct packed {
        logic [NUM_FLOWS-1:0][CREDIT_W-1:0] cnt;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int f = 0; f < NUM_FLOWS; f++) begin
            case (cr_op(take_i[f], add_i[f], st_q.cnt[f] == CREDIT_W'(MAX_CREDIT)))
                CR_ADD:  st_d.cnt[f] = st_q.cnt[f] + CREDIT_W'(1);
                CR_TAKE: st_d.cnt[f] = st_q.cnt[f] - CREDIT_W'(1);
                default: st_d.cnt[f] = st_q.cnt[f];
            endcase
            live_o[f] = (st_q.cnt[f] != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FLOWS; f++)
                st_q.cnt[f] <= CREDIT_W'(INIT_CREDIT);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_chk
        // R2: a counter at zero is never charged
        a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            take_i[g] |-> st_q.cnt[g] != '0);
        // R4: the count never passes its ceiling
        a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[g] <= CREDIT_W'(MAX_CREDIT));
        // R4: a lone return below the ceiling adds exactly one
        a_r4_return_adds: assert property (@(posedge clk) disable iff (!rst_n)
            (add_i[g] && !take_i[g] && st_q.cnt[g] < CREDIT_W'(MAX_CREDIT))
            |=> st_q.cnt[g] == $past(st_q.cnt[g]) + CREDIT_W'(1));
        // R5: return and grant together leave the count alone
        a_r5_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (add_i[g] && take_i[g]) |=> $stable(st_q.cnt[g]));
    end

endmodule

// File: rtl/fcg_rr_arbiter.sv
`timescale 1ns/1ps
module fcg_rr_arbiter #(
    parameter  int NUM_FLOWS = 4,
    localparam int FLOW_W    = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLOWS-1:0] req_i,
    input  logic                 open_i,
    output logic [NUM_FLOWS-1:0] gnt_o,
    output logic [FLOW_W-1:0]    win_o
);

    typedef struct packed {
        logic [FLOW_W-1:0] ptr;
    } arb_t;

    arb_t st_d, st_q;
    logic found;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        win_o = '0;
        for (int i = 1; i <= NUM_FLOWS; i++) begin
            int idx;
            idx = (int'(st_q.ptr) + i) % NUM_FLOWS;
            if (!found && req_i[idx]) begin
                found = 1'b1;
                win_o = FLOW_W'(idx);
            end
        end
        gnt_o = '0;
        if (open_i && found) begin
            gnt_o[win_o] = 1'b1;
            st_d.ptr     = win_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.ptr <= FLOW_W'(NUM_FLOWS - 1);
        else
            st_q <= st_d;
    end

    // R9: at most one flow is granted per cycle
    a_r9_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    // R2: only a candidate presented to the arbiter can win
    a_r2_grant_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);
    // R3: an open slot with any candidate is never wasted
    a_r3_no_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && (|req_i)) |-> (|gnt_o));

endmodule

// File: rtl/fcg_out_stage.sv
`timescale 1ns/1ps
module fcg_out_stage #(
    parameter int FLOW_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FLOW_W-1:0] flow_i,
    input  logic              mark_i,
    input  logic              ready_i,
    output logic              open_o,
    output logic              valid_o,
    output logic [FLOW_W-1:0] flow_o,
    output logic              mark_o
);

    typedef struct packed {
        logic              valid;
        logic [FLOW_W-1:0] flow;
        logic              mark;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ready_i)
            st_d.valid = 1'b0;
        if (load_i) begin
            st_d.valid = 1'b1;
            st_d.flow  = flow_i;
            st_d.mark  = mark_i;
        end
        open_o  = !st_q.valid || ready_i;
        valid_o = st_q.valid;
        flow_o  = st_q.flow;
        mark_o  = st_q.mark;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R9: a stalled packet keeps its contents
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(flow_o) && $stable(mark_o)));
    // R9: a load only happens into a free or draining slot
    a_r9_load_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> open_o);
    // R9: a loaded packet is visible in the next cycle
    a_r9_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (valid_o && flow_o == $past(flow_i)));

endmodule

// File: rtl/flow_credit_gate.sv
`timescale 1ns/1ps
module flow_credit_gate #(
    parameter  int NUM_FLOWS   = 4,
    parameter  int MAX_CREDIT  = 8,
    parameter  int INIT_CREDIT = 4,
    parameter  int BUF_DEPTH   = 128,
    localparam int FLOW_W      = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
    localparam int OCC_W       = $clog2(BUF_DEPTH + 1),
    localparam int HALF_MARK   = BUF_DEPTH / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLOWS-1:0] flow_req_i,
    output logic [NUM_FLOWS-1:0] flow_pop_o,
    input  logic                 ret_valid_i,
    input  logic [FLOW_W-1:0]    ret_flow_i,
    input  logic [OCC_W-1:0]     occ_i,
    output logic                 out_valid_o,
    input  logic                 out_ready_i,
    output logic [FLOW_W-1:0]    out_flow_o,
    output logic                 out_mark_o
);

    logic [NUM_FLOWS-1:0] ret_hot;
    logic [NUM_FLOWS-1:0] live;
    logic [NUM_FLOWS-1:0] eligible;
    logic [NUM_FLOWS-1:0] gnt;
    logic [FLOW_W-1:0]    win;
    logic                 open;
    logic                 load;
    logic                 mark_now;

    always_comb begin
        for (int f = 0; f < NUM_FLOWS; f++)
            ret_hot[f] = ret_valid_i && (ret_flow_i == FLOW_W'(f));
        eligible   = flow_req_i & live;
        load       = |gnt;
        mark_now   = occ_i > OCC_W'(HALF_MARK);
        flow_pop_o = gnt;
    end

    fcg_credit_bank #(
        .NUM_FLOWS  (NUM_FLOWS),
        .MAX_CREDIT (MAX_CREDIT),
        .INIT_CREDIT(INIT_CREDIT)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .take_i(gnt),
        .add_i (ret_hot),
        .live_o(live)
    );

    fcg_rr_arbiter #(
        .NUM_FLOWS(NUM_FLOWS)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (eligible),
        .open_i(open),
        .gnt_o (gnt),
        .win_o (win)
    );

    fcg_out_stage #(
        .FLOW_W(FLOW_W)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .flow_i (win),
        .mark_i (mark_now),
        .ready_i(out_ready_i),
        .open_o (open),
        .valid_o(out_valid_o),
        .flow_o (out_flow_o),
        .mark_o (out_mark_o)
    );

    // R2: the popped flow held credit in the cycle it was taken
    a_r2_pop_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_pop_o & ~live) == '0);
    // R2: the popped flow was actually requesting
    a_r2_pop_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_pop_o & ~flow_req_i) == '0);
    // R7: a grant above half occupancy leaves marked
    a_r7_mark_above_half: assert property (@(posedge clk) disable iff (!rst_n)
        (load && occ_i > OCC_W'(HALF_MARK)) |=> out_mark_o);
    // R8: a grant at or below half occupancy leaves unmarked
    a_r8_clear_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        (load && occ_i <= OCC_W'(HALF_MARK)) |=> !out_mark_o);

endmodule

// File: tb/flow_credit_gate_tb.sv
`timescale 1ns/1ps
module flow_credit_gate_tb;

    localparam int NF    = 4;
    localparam int MAXC  = 8;
    localparam int INITC = 4;
    localparam int DEPTH = 128;
    localparam int HALF  = DEPTH / 2;

    typedef struct {
        int    flow;
        bit    mark;
        string tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] flow_req_i = '0;
    logic [NF-1:0] flow_pop_o;
    logic          ret_valid_i = 1'b0;
    logic [1:0]    ret_flow_i = '0;
    logic [7:0]    occ_i = '0;
    logic          out_valid_o;
    logic          out_ready_i = 1'b0;
    logic [1:0]    out_flow_o;
    logic          out_mark_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_tag  = "R1";
    item_t sbq[$];
    int    m_cred[NF];
    int    m_ptr;
    int    gcount[NF];

    always #10 clk = ~clk;

    flow_credit_gate #(
        .NUM_FLOWS(NF), .MAX_CREDIT(MAXC), .INIT_CREDIT(INITC), .BUF_DEPTH(DEPTH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .flow_req_i(flow_req_i), .flow_pop_o(flow_pop_o),
        .ret_valid_i(ret_valid_i), .ret_flow_i(ret_flow_i), .occ_i(occ_i),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_flow_o(out_flow_o), .out_mark_o(out_mark_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: applies one cycle of stimulus, predicts the grant, queues the expected packet
    task automatic drive(input logic [NF-1:0] req, input bit rv, input int rf,
                         input int occ, input bit rdy);
        int            win;
        logic [NF-1:0] exp_pop;
        @(negedge clk);
        flow_req_i  = req;
        ret_valid_i = rv;
        ret_flow_i  = 2'(rf);
        occ_i       = 8'(occ);
        out_ready_i = rdy;
        #1;
        win     = -1;
        exp_pop = '0;
        if (!out_valid_o || rdy) begin
            for (int i = 1; i <= NF; i++) begin
                int idx;
                idx = (m_ptr + i) % NF;
                if (win < 0 && req[idx] && m_cred[idx] > 0) win = idx;
            end
        end
        if (win >= 0) exp_pop[win] = 1'b1;
        chk(flow_pop_o == exp_pop, cur_tag, int'(flow_pop_o), int'(exp_pop));
        if (win >= 0) begin
            item_t it;
            it.flow = win;
            it.mark = (occ > HALF);
            it.tag  = cur_tag;
            sbq.push_back(it);
            m_cred[win]--;
            m_ptr = win;
            gcount[win]++;
        end
        if (rv) m_cred[rf] = (m_cred[rf] + 1 > MAXC) ? MAXC : m_cred[rf] + 1;
    endtask

    // Monitor: compares each accepted output packet and watches stalls
    bit       stall_prev = 1'b0;
    int       prev_flow  = 0;
    bit       prev_mark  = 1'b0;
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            if (stall_prev)
                chk(out_valid_o && int'(out_flow_o) == prev_flow && out_mark_o == prev_mark,
                    "R9", int'({out_valid_o, out_flow_o, out_mark_o}),
                    int'({1'b1, 2'(prev_flow), prev_mark}));
            stall_prev = out_valid_o && !out_ready_i;
            prev_flow  = int'(out_flow_o);
            prev_mark  = out_mark_o;
            if (out_valid_o && out_ready_i) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R9", int'(out_flow_o), -1);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(int'(out_flow_o) == it.flow && out_mark_o == it.mark, it.tag,
                        int'(out_flow_o) * 2 + int'(out_mark_o), it.flow * 2 + int'(it.mark));
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R9: watchdog expired, actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int snap[NF];
        for (int f = 0; f < NF; f++) begin
            m_cred[f] = INITC;
            gcount[f] = 0;
        end
        m_ptr = NF - 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle state after reset
        cur_tag = "R1";
        drive(4'b0000, 0, 0, 0, 1);
        chk(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);
        drive(4'b0000, 0, 0, 0, 1);
        chk(out_valid_o == 1'b0, "R1", int'(out_valid_o), 0);

        // R6: all flows request, round-robin order, credits drain (R2)
        cur_tag = "R6";
        for (int c = 0; c < 22; c++) drive(4'b1111, 0, 0, 10, 1);
        for (int f = 0; f < NF; f++) chk(gcount[f] == INITC, "R1", gcount[f], INITC);
        cur_tag = "R2";
        drive(4'b1111, 0, 0, 10, 1);
        chk(flow_pop_o == '0, "R2", int'(flow_pop_o), 0);

        // R3: only flow 2 regains credit; it runs while the others stay blocked
        cur_tag = "R3";
        for (int f = 0; f < NF; f++) snap[f] = gcount[f];
        drive(4'b1111, 1, 2, 20, 1);
        drive(4'b1111, 1, 2, 20, 1);
        for (int c = 0; c < 4; c++) drive(4'b1111, 0, 0, 20, 1);
        chk(gcount[2] - snap[2] == 2, "R3", gcount[2] - snap[2], 2);
        chk(gcount[0] + gcount[1] + gcount[3] == snap[0] + snap[1] + snap[3], "R3",
            gcount[0] + gcount[1] + gcount[3], snap[0] + snap[1] + snap[3]);

        // R4: returns to an idle flow saturate at the ceiling
        cur_tag = "R4";
        for (int c = 0; c < 12; c++) drive(4'b0000, 1, 1, 30, 1);
        snap[1] = gcount[1];
        for (int c = 0; c < 14; c++) drive(4'b0010, 0, 0, 30, 1);
        chk(gcount[1] - snap[1] == MAXC, "R4", gcount[1] - snap[1], MAXC);

        // R5: return and grant together on flow 3 keep its single credit
        cur_tag = "R5";
        drive(4'b0000, 1, 3, 30, 1);
        snap[3] = gcount[3];
        drive(4'b1000, 1, 3, 30, 1);
        for (int c = 0; c < 4; c++) drive(4'b1000, 0, 0, 30, 1);
        chk(gcount[3] - snap[3] == 2, "R5", gcount[3] - snap[3], 2);

        // R7 and R8: mark decided by occupancy at grant time
        cur_tag = "R8";
        for (int c = 0; c < 6; c++) drive(4'b0000, 1, 0, 0, 1);
        drive(4'b0001, 0, 0, HALF, 1);
        cur_tag = "R7";
        drive(4'b0001, 0, 0, HALF + 1, 1);
        drive(4'b0001, 0, 0, DEPTH, 1);
        cur_tag = "R8";
        drive(4'b0001, 0, 0, 0, 1);
        drive(4'b0000, 0, 0, 0, 1);
        chk(out_valid_o == 1'b1 && out_mark_o == 1'b0, "R8", int'(out_mark_o), 0);

        // R9: back-pressure holds the output and blocks further grants
        cur_tag = "R9";
        drive(4'b0001, 0, 0, 90, 1);
        for (int c = 0; c < 4; c++) drive(4'b0001, 0, 0, 90, 0);
        chk(flow_pop_o == '0, "R9", int'(flow_pop_o), 0);
        for (int c = 0; c < 4; c++) drive(4'b0000, 0, 0, 0, 1);
        chk(sbq.size() == 0, "R9", sbq.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule